// File: doc/BRIEF.md
# Bus Address Decoder with Boot Overlay

This block routes each request on a 24-bit, big-endian, byte-addressed bus to exactly one target: the RAM, the ROM, or one of ten peripheral windows. A request carries an address, a transfer size of one, two or four bytes, and a read/write flag. The decoder returns a one-hot target select, the offset of the access relative to the chosen target, and an error flag. Four software-programmable regions sit on top of the fixed map. The RAM has a read-only region and a read-write region. The ROM has a read-only region and a read-write region, and the ROM read-write region is backed by RAM. The lowest 1 KiB of the address space is an exception-vector fallback that lives in RAM.

After reset a boot overlay is in force. During the overlay only the two long-word vector fetches at addresses 0 and 4 are legal, and both are steered into the ROM. The fetch at address 4 ends the overlay for good. Peripheral windows whose base address is odd sit on one byte lane of a 16-bit bus, so their offsets are halved.

Requests enter on a valid/ready handshake and responses leave on a valid/ready handshake. A single response register sits between them. A request is taken while `req_ready` is high, which holds whenever the response register is empty or is being drained in the same cycle. A response stays unchanged while `rsp_ready` is low, and no new request is taken during that time. The region bounds are written through a plain configuration port, and a write takes effect from the next cycle.

Top module: `addr_route_dec`

## Requirements
- R1: Out of reset, `rsp_valid` is low, `req_ready` is high and the boot overlay is active. All eight bound registers are zero, so no programmable region matches any address until it is written.
- R2: While the overlay is active, a long read (size code 2) at address 0 or 4 selects the ROM (select bit 1) with offset equal to the address. Any other access returns an error and leaves the overlay active. The accepted read at address 4 ends the overlay, and it never comes back before the next reset.
- R3: Size codes are 0 for one byte, 1 for two bytes and 2 for four bytes. Code 3 always returns an error. An access matches a programmable region or the vector area only if begin <= address and address + bytes <= end, so the whole access has to fit.
- R4: Matches are taken in this order: RAM read-only, RAM read-write, ROM read-only, ROM read-write, peripheral windows, vector area. A RAM region hit selects the RAM (select bit 0) with offset equal to the address. A ROM read-only hit selects the ROM (select bit 1) with offset equal to the address minus 0x100000, taken modulo 2^24.
- R5: Both read-only regions are skipped for writes. A write that lands in a read-only region goes to the next matching target, or returns an error if nothing else matches.
- R6: An access that hits the ROM read-write region selects the RAM (select bit 0) with offset equal to the address.
- R7: Select bit 2+k marks peripheral window k. Windows 0 and 1 are [0x180000,0x200000) and [0x200000,0x280000). Windows 2 to 9 each span 0x4000 bytes and start at 0x3A0001 + (k-2)*0x4000. Each window is half-open, and no fit check is made on the size. The offset is address minus base, halved when the base is odd.
- R8: An access that matches nothing above but satisfies address + bytes <= 0x400 selects the RAM with offset equal to the address.
- R9: An access that matches nothing returns an error with select and offset both zero.
- R10: A request accepted at one clock edge is visible on the response outputs after that edge. While `rsp_valid` is high and `rsp_ready` is low, the response holds and `req_ready` is low.
- R11: A bound written in the same cycle that a request is accepted does not affect that request. It applies from the next request on. Bound index 0/1 holds the RAM read-only begin/end, 2/3 the RAM read-write begin/end, 4/5 the ROM read-only begin/end, and 6/7 the ROM read-write begin/end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Bound register write strobe |
| cfg_idx | input | 3 | Bound register index |
| cfg_data | input | 24 | Bound value to write |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_addr | input | 24 | Byte address |
| req_size | input | 2 | Size code (0 byte, 1 word, 2 long, 3 illegal) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_sel | output | 12 | One-hot target select |
| rsp_off | output | 24 | Offset within the chosen target |
| rsp_err | output | 1 | Bus error |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a bound register write and the acceptance of a request. The bench provokes it by raising `cfg_we` on the same edge that takes a request lying just past the old end of a region. That request must see the old bounds and fail, and a repeat of it must then hit the widened region. The second pair is draining a held response and accepting a new request. The bench stalls `rsp_ready` while a second request waits, then releases it. The first response must stay frozen, and the second must replace it exactly one edge later. Around these cases, sweeps walk every size and direction across each region, window and vector-area boundary, both before and after the bounds are programmed, and compare each result with an arithmetic model of the map.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } xfer_size_e;

  // Programmable regions, in decode priority order
  localparam int unsigned NUM_REGIONS = 4;
  localparam int unsigned RG_RAM_RO   = 0;
  localparam int unsigned RG_RAM_RW   = 1;
  localparam int unsigned RG_ROM_RO   = 2;
  localparam int unsigned RG_ROM_RW   = 3;

  // Fixed select bit positions
  localparam int unsigned SEL_RAM  = 0;
  localparam int unsigned SEL_ROM  = 1;
  localparam int unsigned SEL_WIN0 = 2;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      SZ_LONG: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/addr_route_bounds.sv
module addr_route_bounds #(
  parameter int ADDR_W = 24,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(2 * NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [IDX_W-1:0]             cfg_idx,
  input  logic [ADDR_W-1:0]            cfg_data,
  output logic [NREG-1:0][ADDR_W-1:0]  beg_o,
  output logic [NREG-1:0][ADDR_W-1:0]  lim_o
);

  logic [2*NREG-1:0][ADDR_W-1:0] bank_q;

  // Zero begin and zero end: nothing can fit, so every region starts empty
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (cfg_we) begin
      bank_q[cfg_idx] <= cfg_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_pair
    assign beg_o[g] = bank_q[2*g];
    assign lim_o[g] = bank_q[2*g+1];
  end

endmodule

// File: rtl/addr_route_fit.sv
module addr_route_fit #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        nbytes_i,
  input  logic [ADDR_W-1:0] beg_i,
  input  logic [ADDR_W-1:0] lim_i,
  output logic              hit_o
);

  // One extra bit so that the last byte of the access cannot wrap
  logic [ADDR_W:0] tail_x;

  assign tail_x = {1'b0, addr_i} + {{(ADDR_W-2){1'b0}}, nbytes_i};
  assign hit_o  = (nbytes_i != 3'd0) && (addr_i >= beg_i) &&
                  (tail_x <= {1'b0, lim_i});

endmodule

// File: rtl/addr_route_window.sv
module addr_route_window #(
  parameter int          ADDR_W = 24,
  parameter int unsigned BASE   = 0,
  parameter int unsigned SPAN   = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] off_o
);

  localparam logic [ADDR_W:0] LO_X = (ADDR_W+1)'(BASE);
  localparam logic [ADDR_W:0] HI_X = (ADDR_W+1)'(BASE + SPAN);

  logic [ADDR_W-1:0] delta;

  assign delta = addr_i - LO_X[ADDR_W-1:0];
  assign hit_o = ({1'b0, addr_i} >= LO_X) && ({1'b0, addr_i} < HI_X);

  // An odd base marks a device on one byte lane: its registers are two apart
  if ((BASE % 2) == 1) begin : g_lane
    assign off_o = delta >> 1;
  end else begin : g_flat
    assign off_o = delta;
  end

endmodule

// File: rtl/addr_route_overlay.sv
module addr_route_overlay #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              write_i,
  output logic              active_o,
  output logic              fetch_ok_o
);
  import addr_route_pkg::*;

  logic is_lo, is_hi;

  assign is_lo      = (addr_i == ADDR_W'(0));
  assign is_hi      = (addr_i == ADDR_W'(4));
  assign fetch_ok_o = !write_i && (size_i == SZ_LONG) && (is_lo || is_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_o <= 1'b1;
    end else if (accept_i && active_o && fetch_ok_o && is_hi) begin
      active_o <= 1'b0;
    end
  end

endmodule

// File: rtl/addr_route_dec.sv
module addr_route_dec #(
  parameter int          ADDR_W     = 24,
  parameter int unsigned RAM_BASE   = 32'h000000,
  parameter int unsigned ROM_BASE   = 32'h100000,
  parameter int unsigned VEC_SIZE   = 32'h400,
  parameter int          NUM_LARGE  = 2,
  parameter int unsigned LARGE_BASE = 32'h180000,
  parameter int unsigned LARGE_SPAN = 32'h080000,
  parameter int          NUM_SMALL  = 8,
  parameter int unsigned SMALL_BASE = 32'h3A0001,
  parameter int unsigned SMALL_SPAN = 32'h004000,
  localparam int NUM_WIN   = NUM_LARGE + NUM_SMALL,
  localparam int SEL_W     = 2 + NUM_WIN,
  localparam int CFG_IDX_W = $clog2(2 * addr_route_pkg::NUM_REGIONS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic [ADDR_W-1:0]    cfg_data,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_write,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [SEL_W-1:0]     rsp_sel,
  output logic [ADDR_W-1:0]    rsp_off,
  output logic                 rsp_err
);
  import addr_route_pkg::*;

  localparam logic [ADDR_W-1:0] RAM_B   = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] ROM_B   = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] VEC_LIM = ADDR_W'(VEC_SIZE);

  logic                               accept;
  logic [2:0]                         nbytes;
  logic [NUM_REGIONS-1:0][ADDR_W-1:0] rg_beg, rg_lim;
  logic [NUM_REGIONS-1:0]             rg_hit;
  logic                               vec_hit;
  logic [NUM_WIN-1:0]                 win_hit;
  logic [NUM_WIN-1:0][ADDR_W-1:0]     win_off;
  logic                               ovl_active, ovl_fetch;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign nbytes    = size_bytes(req_size);

  addr_route_bounds #(.ADDR_W(ADDR_W), .NREG(NUM_REGIONS)) u_bounds (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .beg_o(rg_beg), .lim_o(rg_lim)
  );

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    addr_route_fit #(.ADDR_W(ADDR_W)) u_fit (
      .addr_i(req_addr), .nbytes_i(nbytes), .beg_i(rg_beg[r]),
      .lim_i(rg_lim[r]), .hit_o(rg_hit[r])
    );
  end

  addr_route_fit #(.ADDR_W(ADDR_W)) u_vec_fit (
    .addr_i(req_addr), .nbytes_i(nbytes), .beg_i('0),
    .lim_i(VEC_LIM), .hit_o(vec_hit)
  );

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam int unsigned WB = (k < NUM_LARGE)
        ? LARGE_BASE + k * LARGE_SPAN
        : SMALL_BASE + (k - NUM_LARGE) * SMALL_SPAN;
    localparam int unsigned WS = (k < NUM_LARGE) ? LARGE_SPAN : SMALL_SPAN;
    addr_route_window #(.ADDR_W(ADDR_W), .BASE(WB), .SPAN(WS)) u_win (
      .addr_i(req_addr), .hit_o(win_hit[k]), .off_o(win_off[k])
    );
  end

  addr_route_overlay #(.ADDR_W(ADDR_W)) u_ovl (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .addr_i(req_addr),
    .size_i(req_size), .write_i(req_write),
    .active_o(ovl_active), .fetch_ok_o(ovl_fetch)
  );

  // Lowest-numbered window wins (the windows do not overlap)
  logic [NUM_WIN-1:0] win_sel;
  logic [ADDR_W-1:0]  win_pick_off;
  logic               win_any;

  always_comb begin
    win_sel      = '0;
    win_pick_off = '0;
    win_any      = 1'b0;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (win_hit[k] && !win_any) begin
        win_sel[k]   = 1'b1;
        win_pick_off = win_off[k];
        win_any      = 1'b1;
      end
    end
  end

  // Priority decode
  logic [SEL_W-1:0]  d_sel;
  logic [ADDR_W-1:0] d_off;
  logic              d_err;

  always_comb begin
    d_sel = '0;
    d_off = '0;
    d_err = 1'b0;
    if (req_size == SZ_BAD) begin
      d_err = 1'b1;
    end else if (ovl_active) begin
      if (ovl_fetch) begin
        d_sel[SEL_ROM] = 1'b1;
        d_off          = req_addr;
      end else begin
        d_err = 1'b1;
      end
    end else if (!req_write && rg_hit[RG_RAM_RO]) begin
      d_sel[SEL_RAM] = 1'b1;
      d_off          = req_addr - RAM_B;
    end else if (rg_hit[RG_RAM_RW]) begin
      d_sel[SEL_RAM] = 1'b1;
      d_off          = req_addr - RAM_B;
    end else if (!req_write && rg_hit[RG_ROM_RO]) begin
      d_sel[SEL_ROM] = 1'b1;
      d_off          = req_addr - ROM_B;
    end else if (rg_hit[RG_ROM_RW]) begin
      d_sel[SEL_RAM] = 1'b1;
      d_off          = req_addr - RAM_B;
    end else if (win_any) begin
      d_sel[SEL_W-1:SEL_WIN0] = win_sel;
      d_off                   = win_pick_off;
    end else if (vec_hit) begin
      d_sel[SEL_RAM] = 1'b1;
      d_off          = req_addr - RAM_B;
    end else begin
      d_err = 1'b1;
    end
  end

  // Response register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_sel   <= '0;
      rsp_off   <= '0;
      rsp_err   <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_sel   <= d_sel;
      rsp_off   <= d_off;
      rsp_err   <= d_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/addr_route_chk.sv
module addr_route_chk #(
  parameter int ADDR_W = 24,
  parameter int SEL_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [SEL_W-1:0]  rsp_sel,
  input logic [ADDR_W-1:0] rsp_off,
  input logic              rsp_err,
  input logic              ovl_active
);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_sel) &&
                                $stable(rsp_off) && $stable(rsp_err));

  // R10
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> (rsp_sel == '0) && (rsp_off == '0));

  // R4
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_err |-> $countones(rsp_sel) == 1);

  // R4
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_sel));

  // R2
  ovl_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovl_active |=> !ovl_active);

endmodule

bind addr_route_dec addr_route_chk #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_sel(rsp_sel),
  .rsp_off(rsp_off), .rsp_err(rsp_err), .ovl_active(ovl_active)
);

// File: tb/addr_route_dec_tb_top.sv
module addr_route_dec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [23:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [11:0] rsp_sel;
  logic [23:0] rsp_off;
  logic        rsp_err;

  always #10 clk = ~clk;

  addr_route_dec dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_sel(rsp_sel),
    .rsp_off(rsp_off), .rsp_err(rsp_err)
  );

  int          n_chk = 0;
  int          n_err = 0;
  bit          ovl_m = 1'b1;
  int unsigned bnd[8];
  int unsigned win_lo[10];
  int unsigned win_hi[10];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit fits(input int unsigned a, input int unsigned nb, input int r);
    return (a >= bnd[2*r]) && (a + nb <= bnd[2*r+1]);
  endfunction

  // Expected response from the requirements
  function automatic void model(input int unsigned a, input int sz, input bit wr,
                                output logic [11:0] s, output logic [23:0] o,
                                output bit e, output string tag);
    int unsigned nb;
    s = '0; o = '0; e = 1'b0; tag = "R9";
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
    if (nb == 0) begin e = 1'b1; tag = "R3"; return; end
    if (ovl_m) begin
      tag = "R2";
      if (!wr && sz == 2 && (a == 0 || a == 4)) begin s = 12'h002; o = 24'(a); end
      else e = 1'b1;
      return;
    end
    if (!wr && fits(a, nb, 0))      begin s = 12'h001; o = 24'(a); tag = "R4"; return; end
    if (fits(a, nb, 1))             begin s = 12'h001; o = 24'(a); tag = "R3"; return; end
    if (!wr && fits(a, nb, 2))      begin s = 12'h002; o = 24'(a - 32'h100000); tag = "R4"; return; end
    if (fits(a, nb, 3))             begin s = 12'h001; o = 24'(a); tag = "R6"; return; end
    for (int k = 0; k < 10; k++) begin
      if (a >= win_lo[k] && a < win_hi[k]) begin
        s = 12'h004 << k;
        o = ((win_lo[k] & 1) != 0) ? 24'((a - win_lo[k]) / 2) : 24'(a - win_lo[k]);
        tag = "R7";
        return;
      end
    end
    if (a + nb <= 32'h400) begin s = 12'h001; o = 24'(a); tag = "R8"; return; end
    e = 1'b1;
  endfunction

  // Entered and left at a falling edge
  task automatic xact(input int unsigned a, input int sz, input bit wr);
    logic [11:0] s; logic [23:0] o; bit e; string tag;
    model(a, sz, wr, s, o, e, tag);
    req_addr = 24'(a); req_size = 2'(sz); req_write = wr; req_valid = 1'b1;
    @(posedge clk);
    if (ovl_m && !wr && sz == 2 && a == 4) ovl_m = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R10", "rsp_valid after accept", rsp_valid, 1);
    chk(rsp_sel == s && rsp_off == o && rsp_err == e, tag,
        $sformatf("addr 0x%06h size %0d wr %0d sel/off/err", a, sz, wr),
        {rsp_sel, rsp_off, rsp_err}, {s, o, e});
  endtask

  task automatic cfg(input int idx, input int unsigned val);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_data = 24'(val);
    @(posedge clk);
    bnd[idx] = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sweep();
    int unsigned pts[20] = '{32'h0, 32'h400, 32'h800, 32'h1000, 32'h8000,
                             32'h9000, 32'h100000, 32'h17F000, 32'h180000,
                             32'h181000, 32'h200000, 32'h27FFFF, 32'h280000,
                             32'h3A0001, 32'h3A0100, 32'h3A4001, 32'h3B0001,
                             32'h3BC001, 32'h3C0001, 32'hFFFFFF};
    foreach (pts[i]) begin
      for (int d = -5; d < 5; d++) begin
        for (int sz = 0; sz < 4; sz++) begin
          for (int wr = 0; wr < 2; wr++) begin
            xact((pts[i] + 32'(d)) & 32'hFFFFFF, sz, wr[0]);
          end
        end
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [11:0] s; logic [23:0] o; bit e; string tag;
    logic [11:0] s2; logic [23:0] o2; bit e2; string tag2;
    for (int k = 0; k < 10; k++) begin
      win_lo[k] = (k < 2) ? 32'h180000 + k * 32'h80000 : 32'h3A0001 + (k - 2) * 32'h4000;
      win_hi[k] = win_lo[k] + ((k < 2) ? 32'h80000 : 32'h4000);
    end
    foreach (bnd[i]) bnd[i] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);

    // R2 overlay: stray accesses fail, vector fetches go to ROM
    xact(32'h0, 2, 1'b1);
    xact(32'h8, 2, 1'b0);
    xact(32'h0, 1, 1'b0);
    xact(32'h180000, 2, 1'b0);
    xact(32'h0, 2, 1'b0);
    xact(32'h0, 2, 1'b0);
    xact(32'h4, 2, 1'b0);
    // overlay over: address 0 is now the vector area
    xact(32'h0, 2, 1'b0);
    chk(rsp_sel == 12'h001 && !rsp_err, "R2", "post-overlay fetch at 0",
        {rsp_sel, rsp_err}, {12'h001, 1'b0});
    // R1 bounds empty: 0x1000 matches no region
    xact(32'h1000, 2, 1'b0);
    chk(rsp_err == 1'b1, "R1", "unprogrammed region", rsp_err, 1);

    sweep();

    // Program regions (R5 overlap at 0x180000, R6 at 0x3A0000)
    cfg(0, 32'h300);    cfg(1, 32'h800);
    cfg(2, 32'h1000);   cfg(3, 32'h8000);
    cfg(4, 32'h17F000); cfg(5, 32'h181000);
    cfg(6, 32'h3A0000); cfg(7, 32'h3A0100);

    sweep();

    // R5 explicit: write in ROM read-only region below windows fails
    xact(32'h17F800, 1, 1'b1);
    chk(rsp_err == 1'b1, "R5", "write into read-only only", rsp_err, 1);
    // R4 explicit: ROM read-only outranks window 0 for reads
    xact(32'h180010, 2, 1'b0);
    chk(rsp_sel == 12'h002 && rsp_off == 24'h080010, "R4", "ROM ro over window",
        {rsp_sel, rsp_off}, {12'h002, 24'h080010});

    // R10 back-pressure
    repeat (2) @(negedge clk);
    rsp_ready = 1'b0;
    model(32'h3A4005, 0, 1'b0, s, o, e, tag);
    req_addr = 24'h3A4005; req_size = 2'd0; req_write = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    model(32'h200010, 1, 1'b1, s2, o2, e2, tag2);
    req_addr = 24'h200010; req_size = 2'd1; req_write = 1'b1;
    chk(req_ready == 1'b0, "R10", "req_ready while stalled", req_ready, 0);
    repeat (2) @(negedge clk);
    chk(rsp_valid && rsp_sel == s && rsp_off == o && rsp_err == e, "R10",
        "held response", {rsp_sel, rsp_off, rsp_err}, {s, o, e});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_sel == s2 && rsp_off == o2 && rsp_err == e2, "R10",
        "response after release", {rsp_sel, rsp_off, rsp_err}, {s2, o2, e2});
    @(negedge clk);

    // R11 config write in the same cycle as an accepted request
    cfg_we = 1'b1; cfg_idx = 3'd3; cfg_data = 24'h9000;
    req_addr = 24'h8000; req_size = 2'd2; req_write = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk(rsp_err == 1'b1, "R11", "request uses old bound", rsp_err, 1);
    bnd[3] = 32'h9000;
    xact(32'h8000, 2, 1'b0);
    chk(rsp_sel == 12'h001 && rsp_off == 24'h8000 && !rsp_err, "R11",
        "next request uses new bound", {rsp_sel, rsp_off}, {12'h001, 24'h8000});

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule